// File: doc/BRIEF.md
# CAN Transmitter Enable Guard

This block sits between the transmit data input of a CAN transceiver and its bus driver. It decides, every clock cycle, whether the driver may pull the bus to the dominant level. The driver is allowed to go dominant only when the transmit input is low, the transceiver is in its normal mode, the transmit input has not been stuck low for too long, and no over-temperature shutdown is latched.

There are two protections, and both are released in the same way. A stuck-low transmit input is caught by a dominant timeout counter. Once the timeout fires, the driver is forced recessive. An over-temperature flag cuts the driver at once and sets a shutdown latch. Neither condition clears on a timer or through a register. Both clear only when the synchronized transmit input is seen high. The transmit input goes through a resettable synchronizer that resets to the high (recessive) level. The temperature flag is a digital input, and the mode input selects normal (0) or standby (1).

The timeout is a parameter counted in clock cycles. Its default is 50000 cycles, which is 500 µs at 100 MHz. This is longer than 17 bit times at 40 kbit/s, so legal CAN traffic at that rate never trips it.

Top module: `can_tx_guard`

## Requirements
- R1: During reset and right after it, `drive_dom` is 0. The transmit synchronizer resets to the high (recessive) level.
- R2: In normal mode with no fault, `drive_dom` goes to 1 exactly SYNC_STAGES (default 2) clock edges after `txd` goes low. It returns to 0 SYNC_STAGES edges after `txd` goes high.
- R3: After the synchronized `txd` has been low for TIMEOUT_CYC consecutive cycles, `drive_dom` goes to 0. It stays 0 for as long as `txd` stays low.
- R4: Any high level on the synchronized `txd` resets the timeout count. A new low period therefore gets the full TIMEOUT_CYC window of dominance.
- R5: After a timeout, a high on `txd` followed by a low makes `drive_dom` 1 again after SYNC_STAGES edges.
- R6: `over_temp`=1 forces `drive_dom` to 0 in the same cycle and sets the shutdown latch at the next edge.
- R7: While the latch is set and the synchronized `txd` stays low, `drive_dom` stays 0 even after `over_temp` returns to 0.
- R8: The latch clears only on an edge where the synchronized `txd` is high and `over_temp` is 0. After that, a new low on `txd` gives `drive_dom`=1 again.
- R9: `standby`=1 (standby mode) forces `drive_dom` to 0 in the same cycle. With `standby`=0 (normal mode), dominance returns at once if no other condition blocks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txd | input | 1 | Transmit data from the controller, low means dominant |
| over_temp | input | 1 | Over-temperature flag, 1 means too hot |
| standby | input | 1 | Mode select, 0 normal, 1 standby |
| drive_dom | output | 1 | 1 lets the bus driver drive dominant |

## Verification
The bench covers the following corner cases.
- Timeout edge. It samples `drive_dom` on the last dominant cycle and on the first blocked cycle. A counter that is off by one moves the cut-off by one cycle, and the bench sees it.
- Restart of the timeout window. A short low period is broken by a few high cycles and then followed by a full-length low period. A design that only resets the count on some other event would cut the second period short.
- Thermal latch release. The flag drops while `txd` is still low, and the driver must stay off. A latch that follows the flag level, or that releases on the flag instead of on `txd`, would re-enable the driver too early.
- Instant cut-off. Standby mode and the temperature flag are both checked in the same cycle they assert. A registered gating path would leave the driver dominant for one extra cycle.

// File: rtl/can_guard_pkg.sv
package can_guard_pkg;

    typedef enum logic {
        MODE_NORMAL  = 1'b0,
        MODE_STANDBY = 1'b1
    } tx_mode_e;

    // 17 bit times at 40 kbit/s is 425 us; stay above that.
    localparam int unsigned MIN_TIMEOUT_NS = 425_000;

    function automatic logic gate_open(input logic txd_low,
                                       input tx_mode_e mode,
                                       input logic timed_out,
                                       input logic hot);
        return txd_low && (mode == MODE_NORMAL) && !timed_out && !hot;
    endfunction

endpackage

// File: rtl/can_txd_sync.sv
module can_txd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_raw,
    output logic txd_s
);

    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (STAGES > 1) begin
            st_d.chain = {st_q.chain[STAGES-2:0], txd_raw};
        end else begin
            st_d.chain[0] = txd_raw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign txd_s = st_q.chain[LAST];

    // R1: after reset the synchronized level starts recessive
    a_r1_sync_reset_high: assert property (@(posedge clk)
        $rose(rst_n) |-> txd_s);

endmodule

// File: rtl/can_dom_timer.sv
module can_dom_timer #(
    parameter int unsigned TIMEOUT_CYC = 50_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_s,
    output logic expired
);

    localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fired;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (txd_s) begin
            st_d.cnt   = '0;
            st_d.fired = 1'b0;
        end else begin
            if (st_q.cnt != LIMIT) begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
            st_d.fired = (st_d.cnt == LIMIT);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expired = st_q.fired;

    // R4: any high level clears the window
    a_r4_high_clears: assert property (@(posedge clk) disable iff (!rst_n)
        txd_s |=> (st_q.cnt == '0) && !expired);

    // R3: once fired, stays fired while low
    a_r3_fired_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !txd_s) |=> expired);

    // R3: counter never passes the limit
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LIMIT);

endmodule

// File: rtl/can_therm_latch.sv
module can_therm_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic over_temp,
    input  logic txd_s,
    output logic shut
);

    typedef struct packed {
        logic shut;
    } therm_t;

    therm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (over_temp) begin
            st_d.shut = 1'b1;
        end else if (txd_s) begin
            st_d.shut = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shut = st_q.shut;

    // R6: flag sets latch on next edge
    a_r6_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        over_temp |=> shut);

    // R7: latch holds while transmit input stays low
    a_r7_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (shut && !txd_s) |=> shut);

endmodule

// File: rtl/can_tx_guard.sv
module can_tx_guard #(
    parameter int unsigned TIMEOUT_CYC = 50_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd,
    input  logic over_temp,
    input  logic standby,
    output logic drive_dom
);

    import can_guard_pkg::*;

    localparam int unsigned RW = $clog2(TIMEOUT_CYC + 2) + 1;

    logic     txd_s;
    logic     expired;
    logic     shut;
    tx_mode_e mode;

    can_txd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .txd_raw (txd),
        .txd_s   (txd_s)
    );

    can_dom_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .txd_s   (txd_s),
        .expired (expired)
    );

    can_therm_latch u_therm (
        .clk       (clk),
        .rst_n     (rst_n),
        .over_temp (over_temp),
        .txd_s     (txd_s),
        .shut      (shut)
    );

    assign mode      = standby ? MODE_STANDBY : MODE_NORMAL;
    assign drive_dom = gate_open(!txd_s, mode, expired, shut || over_temp);

    // Checker-side run-length counter for the dominant window bound.
    logic [RW-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (drive_dom) begin
            run_q <= run_q + RW'(1);
        end else begin
            run_q <= '0;
        end
    end

    // R3: no dominant stretch is longer than the timeout
    a_r3_bounded_run: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(TIMEOUT_CYC));

    // R8: dominance never returns from a latched shutdown without a high on txd
    a_r8_release_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
        (shut && !txd_s) |=> !drive_dom);

    // R1: driver is off on the first cycle out of reset
    a_r1_reset_off: assert property (@(posedge clk)
        $rose(rst_n) |-> !drive_dom);

    // R9: standby keeps the driver off
    a_r9_standby_off: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && $past(standby)) |-> !drive_dom);

endmodule

// File: tb/tb_can_tx_guard.sv
module tb_can_tx_guard;

    localparam int unsigned TO = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txd = 1'b1;
    logic over_temp = 1'b0;
    logic standby = 1'b0;
    logic drive_dom;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    can_tx_guard #(.TIMEOUT_CYC(TO), .SYNC_STAGES(2)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .txd       (txd),
        .over_temp (over_temp),
        .standby   (standby),
        .drive_dom (drive_dom)
    );

    task automatic check(input logic exp, input string req, input string what);
        checks++;
        if (drive_dom !== exp) begin
            errors++;
            $display("FAIL %s %s: drive_dom=%b expected=%b", req, what, drive_dom, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic t_reset;
        txd = 1'b0;
        wait_n(2);
        check(1'b0, "R1", "in reset with txd low");
        txd = 1'b1;
        wait_n(1);
        rst_n = 1'b1;
        wait_n(1);
        check(1'b0, "R1", "after reset release");
    endtask

    task automatic t_basic;
        @(negedge clk); txd = 1'b0;
        wait_n(1); check(1'b0, "R2", "one edge after low");
        wait_n(1); check(1'b1, "R2", "two edges after low");
        @(negedge clk); txd = 1'b1;
        wait_n(1); check(1'b1, "R2", "one edge after high");
        wait_n(1); check(1'b0, "R2", "two edges after high");
        wait_n(3);
    endtask

    task automatic t_timeout;
        @(negedge clk); txd = 1'b0;
        wait_n(TO + 1); check(1'b1, "R3", "last dominant cycle");
        wait_n(1);      check(1'b0, "R3", "first blocked cycle");
        wait_n(5);      check(1'b0, "R3", "still blocked while low");
        @(negedge clk); txd = 1'b1;
        wait_n(3);      check(1'b0, "R5", "recessive after release");
        @(negedge clk); txd = 1'b0;
        wait_n(2);      check(1'b1, "R5", "dominant again after timeout");
        @(negedge clk); txd = 1'b1;
        wait_n(3);
    endtask

    task automatic t_retrigger;
        @(negedge clk); txd = 1'b0;
        wait_n(TO - 5);
        txd = 1'b1;
        wait_n(4);
        txd = 1'b0;
        wait_n(TO + 1); check(1'b1, "R4", "full window after short high");
        wait_n(1);      check(1'b0, "R4", "window ends at timeout");
        @(negedge clk); txd = 1'b1;
        wait_n(3);
    endtask

    task automatic t_thermal;
        @(negedge clk); txd = 1'b0;
        wait_n(2); check(1'b1, "R6", "dominant before flag");
        over_temp = 1'b1;
        #1;        check(1'b0, "R6", "same-cycle cut-off");
        wait_n(2);
        over_temp = 1'b0;
        #1;        check(1'b0, "R7", "flag drop with txd low");
        wait_n(4); check(1'b0, "R7", "latch holds while low");
        txd = 1'b1;
        wait_n(3);
        txd = 1'b0;
        wait_n(2); check(1'b1, "R8", "released by high txd");
        // flag raised while txd high, lowered while txd low
        txd = 1'b1;
        wait_n(3);
        over_temp = 1'b1;
        wait_n(2);
        txd = 1'b0;
        wait_n(3); check(1'b0, "R8", "flag held through high period");
        over_temp = 1'b0;
        wait_n(3); check(1'b0, "R8", "no release without high txd");
        txd = 1'b1;
        wait_n(3);
        txd = 1'b0;
        wait_n(2); check(1'b1, "R8", "release after flag clear and high");
        txd = 1'b1;
        wait_n(3);
    endtask

    task automatic t_standby;
        @(negedge clk); txd = 1'b0;
        wait_n(2); check(1'b1, "R9", "normal mode dominant");
        standby = 1'b1;
        #1;        check(1'b0, "R9", "standby same-cycle off");
        wait_n(3); check(1'b0, "R9", "standby holds off");
        standby = 1'b0;
        #1;        check(1'b1, "R9", "back to normal");
        @(negedge clk); txd = 1'b1;
        wait_n(3);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_timeout();
        t_retrigger();
        t_thermal();
        t_standby();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100_000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule